// File: doc/BRIEF.md
# Two-Slice Cascaded Serial-to-Parallel Converter

This block turns a serial bit stream into a parallel word. It is built from two identical six-stage shift slices. The head slice takes the serial input. The tail slice is fed only through the cascade link from the head slice's deepest stages, so the pair acts as one twelve-stage chain. Widths up to six use the head slice alone; wider words reach into the tail slice.

Two clocks drive the block. A fast bit clock moves the chain: on its rising edge only in single-rate mode, or on both edges in double-rate mode. In double-rate mode a pairing stage collects the falling-edge sample, and the chain then advances two positions per bit clock. A slow word clock, with its rising edges aligned to bit-clock rising edges, copies the chain into the output register once per word. The word clock period is W bit periods in single-rate mode and W/2 bit periods in double-rate mode. A synchronous active-high reset clears everything.

Top module: `deser_cascade_top`

## Requirements
- R1: With `ddr_mode` = 0, `ser_in` is sampled on bit-clock rising edges only; its value at falling edges never reaches the word.
- R2: With `ddr_mode` = 1, `ser_in` is sampled on both bit-clock edges. A rising-edge sample counts as earlier than the falling-edge sample that follows it.
- R3: Legal widths are 2 to 8 in single-rate mode and the even values 2 to 10 in double-rate mode. For any other `width` value (0, 1, odd double-rate widths, and anything above the mode's maximum), each word-clock rise loads all zeros.
- R4: Widths above six take their oldest bits from the tail slice. On each bit-clock rise, the head slice's deepest stage moves into the tail slice's first stage in single-rate mode. In double-rate mode, the head slice's two deepest stages move into the tail slice's first two stages in order.
- R5: At each word-clock rise the output loads the W most recent samples already in the chain. In single-rate mode these are the samples from the W preceding bit-clock rises. In double-rate mode the samples taken at the previous bit-clock rise and the falling edge after it are not yet included, because the pairing stage adds one bit period of latency.
- R6: For a legal width W, the first-received bit of the word is at `word[W-1]` and the newest is at `word[0]`. Bits W and above are zero.
- R7: While `rst` is high, a bit-clock rise clears every chain stage and the pairing stage, and a word-clock rise clears `word`.
- R8: `width` is a plain binary count of bits per word. `ddr_mode` is 0 for single-rate and 1 for double-rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Fast bit clock that moves the shift chain |
| word_clk | input | 1 | Slow word clock, rising edges aligned with bit_clk rising edges |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| ddr_mode | input | 1 | 0 = sample on rising edges only, 1 = sample on both edges |
| width | input | 4 | Word width in bits (binary count) |
| ser_in | input | 1 | Serial data input |
| word | output | 12 | Parallel word; first-received bit at word[width-1] |

## Verification
The checker tracks, on every clock, the edges of the chain: where the serial input enters the head slice in single-rate mode, and the transfer of one or two bits across the cascade link into the tail slice. It also checks that reset clears the chain and the word, that bits above the selected width stay zero, and that an illegal width gives a zero word. Only the scoreboard scenarios can show that whole words come out correct and in order, with the right latency at each legal width. This includes that the value on the serial input at falling edges is ignored in single-rate mode and that the tail slice supplies the oldest bits of wide words.

// File: rtl/deser_pkg.sv
`timescale 1ns/1ps
package deser_pkg;

    // Sampling rate of the serial input.
    typedef enum logic {
        RATE_SINGLE = 1'b0,
        RATE_DOUBLE = 1'b1
    } rate_e;

    // Two samples collected within one bit period, oldest first.
    typedef struct packed {
        logic early;
        logic late;
    } bit_pair_t;

    // Width legality per rate: single-rate 2..sdr_max, double-rate even 2..ddr_max.
    function automatic logic width_legal(input rate_e rate, input int w,
                                         input int sdr_max, input int ddr_max);
        if (w < 2) return 1'b0;
        if (rate == RATE_SINGLE) return (w <= sdr_max);
        return (w <= ddr_max) && ((w % 2) == 0);
    endfunction

endpackage

// File: rtl/deser_edge_cap.sv
`timescale 1ns/1ps
module deser_edge_cap
    import deser_pkg::*;
(
    input  logic      bit_clk,
    input  logic      rst,
    input  logic      din,
    output bit_pair_t pair
);

    logic rise_q;
    logic fall_q;

    always_ff @(posedge bit_clk) begin
        if (rst) rise_q <= 1'b0;
        else     rise_q <= din;
    end

    always_ff @(negedge bit_clk) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= din;
    end

    assign pair = '{early: rise_q, late: fall_q};

endmodule

// File: rtl/deser_slice.sv
`timescale 1ns/1ps
module deser_slice
    import deser_pkg::*;
#(
    parameter int BITS = 6
) (
    input  logic            bit_clk,
    input  logic            rst,
    input  rate_e           rate,
    input  logic            feed_one,
    input  bit_pair_t       feed_pair,
    output logic [BITS-1:0] stages
);

    // Stage 0 holds the newest bit; stage BITS-1 the oldest.
    always_ff @(posedge bit_clk) begin
        if (rst) begin
            stages <= '0;
        end else if (rate == RATE_DOUBLE) begin
            stages <= {stages[BITS-3:0], feed_pair.early, feed_pair.late};
        end else begin
            stages <= {stages[BITS-2:0], feed_one};
        end
    end

endmodule

// File: rtl/deser_word_reg.sv
`timescale 1ns/1ps
module deser_word_reg
    import deser_pkg::*;
#(
    parameter int WORD_BITS = 12,
    parameter int WSEL_BITS = 4,
    parameter int SDR_MAX   = 8,
    parameter int DDR_MAX   = 10
) (
    input  logic                 word_clk,
    input  logic                 rst,
    input  rate_e                rate,
    input  logic [WSEL_BITS-1:0] width,
    input  logic [WORD_BITS-1:0] chain,
    output logic [WORD_BITS-1:0] word
);

    logic                 legal;
    logic [WORD_BITS-1:0] keep;

    always_comb begin
        legal = width_legal(rate, int'(width), SDR_MAX, DDR_MAX);
        for (int i = 0; i < WORD_BITS; i++) begin
            keep[i] = legal && (i < int'(width)) && chain[i];
        end
    end

    always_ff @(posedge word_clk) begin
        if (rst) word <= '0;
        else     word <= keep;
    end

endmodule

// File: rtl/deser_cascade_top.sv
`timescale 1ns/1ps
module deser_cascade_top
    import deser_pkg::*;
#(
    parameter  int SLICE_BITS = 6,
    parameter  int SLICES     = 2,
    parameter  int SDR_MAX    = 8,
    parameter  int DDR_MAX    = 10,
    localparam int CHAIN_BITS = SLICE_BITS * SLICES,
    localparam int WSEL_BITS  = $clog2(CHAIN_BITS + 1)
) (
    input  logic                  bit_clk,
    input  logic                  word_clk,
    input  logic                  rst,
    input  logic                  ddr_mode,
    input  logic [WSEL_BITS-1:0]  width,
    input  logic                  ser_in,
    output logic [CHAIN_BITS-1:0] word
);

    rate_e                               rate;
    bit_pair_t                           cap_pair;
    logic [SLICES-1:0][SLICE_BITS-1:0]   stages;

    assign rate = rate_e'(ddr_mode);

    deser_edge_cap u_cap (
        .bit_clk (bit_clk),
        .rst     (rst),
        .din     (ser_in),
        .pair    (cap_pair)
    );

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        logic      feed_one;
        bit_pair_t feed_pair;

        if (g == 0) begin : g_head
            assign feed_one  = ser_in;
            assign feed_pair = cap_pair;
        end else begin : g_link
            // Cascade: deepest stages of the previous slice feed this one.
            assign feed_one  = stages[g-1][SLICE_BITS-1];
            assign feed_pair = '{early: stages[g-1][SLICE_BITS-1],
                                 late:  stages[g-1][SLICE_BITS-2]};
        end

        deser_slice #(.BITS(SLICE_BITS)) u_slice (
            .bit_clk   (bit_clk),
            .rst       (rst),
            .rate      (rate),
            .feed_one  (feed_one),
            .feed_pair (feed_pair),
            .stages    (stages[g])
        );
    end

    deser_word_reg #(
        .WORD_BITS (CHAIN_BITS),
        .WSEL_BITS (WSEL_BITS),
        .SDR_MAX   (SDR_MAX),
        .DDR_MAX   (DDR_MAX)
    ) u_word (
        .word_clk (word_clk),
        .rst      (rst),
        .rate     (rate),
        .width    (width),
        .chain    (stages),
        .word     (word)
    );

endmodule

// File: rtl/deser_chk.sv
`timescale 1ns/1ps
module deser_chk
    import deser_pkg::*;
#(
    parameter int SLICE_BITS = 6,
    parameter int SLICES     = 2,
    parameter int SDR_MAX    = 8,
    parameter int DDR_MAX    = 10,
    parameter int WORD_BITS  = 12,
    parameter int WSEL_BITS  = 4
) (
    input logic                              bit_clk,
    input logic                              word_clk,
    input logic                              rst,
    input logic                              ddr_mode,
    input logic [WSEL_BITS-1:0]              width,
    input logic                              ser_in,
    input logic [WORD_BITS-1:0]              word,
    input logic [SLICES-1:0][SLICE_BITS-1:0] stages
);

    logic cfg_ok;
    logic bstarted = 1'b0;
    logic wstarted = 1'b0;

    assign cfg_ok = width_legal(rate_e'(ddr_mode), int'(width), SDR_MAX, DDR_MAX);

    always_ff @(posedge bit_clk)  bstarted <= 1'b1;
    always_ff @(posedge word_clk) wstarted <= 1'b1;

    // R1
    sdr_entry_chk: assert property (@(posedge bit_clk) disable iff (rst)
        (!$past(rst) && !$past(ddr_mode)) |-> (stages[0][0] == $past(ser_in)));

    // R4
    casc_single_chk: assert property (@(posedge bit_clk) disable iff (rst)
        (!$past(rst) && !$past(ddr_mode)) |-> (stages[1][0] == $past(stages[0][SLICE_BITS-1])));

    // R4
    casc_double_chk: assert property (@(posedge bit_clk) disable iff (rst)
        (!$past(rst) && $past(ddr_mode)) |-> (stages[1][1:0] == $past(stages[0][SLICE_BITS-1 -: 2])));

    // R3
    illegal_zero_chk: assert property (@(posedge word_clk) disable iff (rst)
        !$past(cfg_ok) |-> (word == '0));

    // R6
    upper_zero_chk: assert property (@(posedge word_clk) disable iff (rst)
        $past(cfg_ok) |-> ((word >> $past(width)) == '0));

    // R7
    chain_reset_chk: assert property (@(posedge bit_clk) disable iff (!bstarted)
        $past(rst) |-> (stages == '0));

    // R7
    word_reset_chk: assert property (@(posedge word_clk) disable iff (!wstarted)
        $past(rst) |-> (word == '0));

endmodule

bind deser_cascade_top deser_chk #(
    .SLICE_BITS (SLICE_BITS),
    .SLICES     (SLICES),
    .SDR_MAX    (SDR_MAX),
    .DDR_MAX    (DDR_MAX),
    .WORD_BITS  (CHAIN_BITS),
    .WSEL_BITS  (WSEL_BITS)
) u_chk (
    .bit_clk  (bit_clk),
    .word_clk (word_clk),
    .rst      (rst),
    .ddr_mode (ddr_mode),
    .width    (width),
    .ser_in   (ser_in),
    .word     (word),
    .stages   (stages)
);

// File: tb/tb_deser_cascade_top.sv
`timescale 1ns/1ps
module tb_deser_cascade_top;

    localparam int SB = 6;
    localparam int NS = 2;
    localparam int WB = SB * NS;
    localparam int WS = $clog2(WB + 1);

    logic          bclk = 1'b0;
    logic          wclk = 1'b0;
    logic          rst  = 1'b1;
    logic          ddr  = 1'b0;
    logic          din  = 1'b0;
    logic [WS-1:0] wsel = WS'(4);
    logic [WB-1:0] word;

    deser_cascade_top dut (
        .bit_clk  (bclk),
        .word_clk (wclk),
        .rst      (rst),
        .ddr_mode (ddr),
        .width    (wsel),
        .ser_in   (din),
        .word     (word)
    );

    int    total    = 0;
    int    bad      = 0;
    bit    finished = 1'b0;
    logic  rst_want = 1'b1;
    int    per      = 4;
    int    cnt      = 0;
    string cur_tag  = "R7";
    logic [15:0] lfsr = 16'hACE1;

    logic          smp[$];
    logic [WB-1:0] exp_q[$];
    string         tag_q[$];

    // Legal widths (R3, R8): single-rate 2..8, double-rate even 2..10.
    function automatic bit tb_legal(input bit d, input int w);
        if (d) return (w == 2) || (w == 4) || (w == 6) || (w == 8) || (w == 10);
        return (w >= 2) && (w <= 8);
    endfunction

    function automatic logic nextbit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Driver side of the scoreboard: expected word for this word-clock rise.
    task automatic push_expect();
        logic [WB-1:0] e = '0;
        string t;
        int n;
        if (rst) begin
            t = "R7";
        end else if (!tb_legal(ddr, int'(wsel))) begin
            t = "R3";
        end else begin
            t = cur_tag;
            n = smp.size() - (ddr ? 2 : 0);   // R5: pairing latency in double rate
            for (int i = 0; i < int'(wsel); i++) begin
                if (n - 1 - i >= 0) e[i] = smp[n - 1 - i];   // R6: newest at bit 0
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // One bit period: rise, data change, fall, data change.
    task automatic bit_cycle();
        if (cnt == 0) begin
            push_expect();
            wclk = 1'b1;
        end
        bclk = 1'b1;
        if (!rst) smp.push_back(din);
        cnt = (cnt + 1 >= per) ? 0 : cnt + 1;
        #1.25;
        din = nextbit();            // R1: junk in single rate, seen only at the falling edge
        #1.25;
        bclk = 1'b0;
        wclk = 1'b0;
        if (ddr && !rst) smp.push_back(din);
        #1.25;
        rst = rst_want;
        if (rst) smp.delete();
        din = nextbit();
        #1.25;
    endtask

    task automatic scenario(input bit d, input int w, input int words, input string tag);
        rst_want = 1'b1;
        bit_cycle();
        ddr     = d;
        wsel    = WS'(w);
        per     = tb_legal(d, w) ? (d ? w / 2 : w) : 4;
        cnt     = 0;
        cur_tag = tag;
        repeat (3 * per + 2) bit_cycle();
        rst_want = 1'b0;
        repeat (words * per + 1) bit_cycle();
    endtask

    // Monitor side of the scoreboard.
    initial begin
        logic [WB-1:0] e;
        string t;
        forever begin
            @(posedge wclk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (word !== e) begin
                    bad++;
                    $display("FAIL %s: word=%h expected=%h (width=%0d ddr=%0d)",
                             t, word, e, wsel, ddr);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            bad++;
            $display("FAIL R5 watchdog: finished=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (8) bit_cycle();                       // R7 reset state
        for (int w = 2; w <= 8; w++) begin
            if (w > 6) scenario(1'b0, w, 12, "R1 R4 R5 R6 R8");
            else       scenario(1'b0, w, 12, "R1 R5 R6 R8");
        end
        for (int w = 2; w <= 10; w += 2) begin
            if (w > 6) scenario(1'b1, w, 12, "R2 R4 R5 R6 R8");
            else       scenario(1'b1, w, 12, "R2 R5 R6 R8");
        end
        scenario(1'b0, 9, 6, "R3");
        scenario(1'b0, 1, 6, "R3");
        scenario(1'b0, 0, 6, "R3");
        scenario(1'b1, 7, 6, "R3");
        scenario(1'b1, 12, 6, "R3");
        scenario(1'b1, 10, 4, "R2 R4 R5 R6");
        rst_want = 1'b1;                              // R7: reset after live data
        repeat (10) bit_cycle();
        #5;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule